// File: doc/BRIEF.md
# Open-Drain Pin Port with Per-Pin Sink Strength and Edge Interrupts

This block controls an eight-pin I/O port in which every pin either floats high through an internal pull-up or pulls low through a programmable current sink. Software writes a data bit per pin. A 1 releases the sink and enables the pull-up, which also makes the pin usable as an input. A 0 turns the pull-up off and enables the sink at the pin's own 4-bit strength code. The analog sinks and resistors live in the pad. This block only produces their control signals, plus a flag per pin that tells the pad which current class the pin belongs to.

The block samples the pin levels through a two-flop synchroniser. It detects a rising or a falling edge on each pin, as chosen by that pin's polarity bit. An edge on a pin whose mask bit is set is latched into a pending register. All pending bits that are still masked are ORed into a single interrupt request. Software clears a pending bit by writing 1 to it.

Top module: `pinport_ctrl`

## Requirements
- R1: A write to address 0x0 with bit n = 1 sets `pu_en[n]`=1 and `sink_en[n]`=0 from the clock edge that takes the write.
- R2: A write to address 0x0 with bit n = 0 sets `pu_en[n]`=0 and `sink_en[n]`=1 from the clock edge that takes the write. `sink_en` is always the complement of `pu_en`.
- R3: A read at address 0x0 returns the synchronised pin levels. A change on `pin_in` first shows up in the read after two rising clock edges.
- R4: Address 0x8+n holds pin n's 4-bit strength code in write-data bits 3:0. It drives `sink_code[4n+3:4n]` and reads back zero-extended.
- R5: `hi_class` is 1 for pins 1:0 (high-current class) and 0 for pins 7:2.
- R6: Mask register at address 0x1: bit n = 1 lets pin n latch edges. An edge on a pin whose mask bit is 0 leaves the pending register unchanged.
- R7: Polarity register at address 0x2: bit n = 0 selects rising edges (0 to 1) and bit n = 1 selects falling edges (1 to 0). An edge of the opposite direction is ignored.
- R8: Pending register read at address 0x3. Writing 1 to a bit clears it. Writing 0 leaves it unchanged. An edge arriving in the same cycle as a clear wins.
- R9: `irq` is high while any pending bit has its mask bit set. It rises after the third rising clock edge that follows a qualifying pin change.
- R10: After reset the data register reads 0xFF (all pull-ups on), all sink codes are 0, mask, polarity and pending are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_in | input | 8 | Pin levels from the pads (asynchronous) |
| pu_en | output | 8 | Per-pin pull-up enable |
| sink_en | output | 8 | Per-pin current-sink enable |
| sink_code | output | 32 | Per-pin 4-bit sink strength, pin n in bits 4n+3:4n |
| hi_class | output | 8 | Per-pin high-current class flag |
| irq | output | 1 | Port interrupt request |

## Verification
Register writes take effect at the clock edge that accepts the strobe. The bench drives each write from one falling edge to the next and checks the outputs just after that second falling edge. A pin change crosses two synchroniser flops, so the level read-back is due two rising edges later. The pending bit and `irq` are due one edge after that, on the third edge. The bench checks one edge early to confirm that nothing has arrived yet, and again on time to confirm that the result is present. In the random phase the pins change only after the previous change has fully settled through the pending stage, so the bench's model always matches a settled design.

// File: rtl/pinport_pkg.sv
`timescale 1ns/1ps
// Package: register addresses and helper types shared by the pin port.
// Assumes an address space of 2*N_PINS locations with the per-pin code
// registers occupying the upper half.
package pinport_pkg;
    localparam int unsigned ADDR_DATA = 0;
    localparam int unsigned ADDR_MASK = 1;
    localparam int unsigned ADDR_POL  = 2;
    localparam int unsigned ADDR_PEND = 3;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1
    } edge_sel_e;
endpackage

// File: rtl/pinport_regs.sv
`timescale 1ns/1ps
// Module: register file of the pin port. Holds the data, mask, polarity and
// per-pin sink codes, decodes pending-clear writes and muxes read data.
// Assumes N_PINS >= CODE_W and N_PINS >= 4 so the lower addresses fit.
module pinport_regs
    import pinport_pkg::*;
#(
    parameter int unsigned N_PINS = 8,
    parameter int unsigned CODE_W = 4,
    localparam int unsigned IDX_W  = $clog2(N_PINS),
    localparam int unsigned ADDR_W = IDX_W + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [N_PINS-1:0]             wdata,
    input  logic [N_PINS-1:0]             pin_lvl,
    input  logic [N_PINS-1:0]             pend,
    output logic [N_PINS-1:0]             rdata,
    output logic [N_PINS-1:0]             data_q,
    output logic [N_PINS-1:0]             mask_q,
    output logic [N_PINS-1:0]             pol_q,
    output logic [N_PINS-1:0]             pend_clr,
    output logic [N_PINS-1:0][CODE_W-1:0] code_q
);
    logic             code_sel;
    logic [IDX_W-1:0] code_idx;

    assign code_sel = addr[ADDR_W-1];
    assign code_idx = addr[IDX_W-1:0];

    // Control registers: data resets to all ones, the others to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '1;
            mask_q <= '0;
            pol_q  <= '0;
        end else if (wr && !code_sel) begin
            if (code_idx == IDX_W'(ADDR_DATA)) data_q <= wdata;
            if (code_idx == IDX_W'(ADDR_MASK)) mask_q <= wdata;
            if (code_idx == IDX_W'(ADDR_POL))  pol_q  <= wdata;
        end
    end

    // One sink-strength register per pin.
    for (genvar i = 0; i < N_PINS; i++) begin : g_code
        always_ff @(posedge clk) begin
            if (!rst_n)
                code_q[i] <= '0;
            else if (wr && code_sel && code_idx == IDX_W'(i))
                code_q[i] <= wdata[CODE_W-1:0];
        end
    end

    // Write-one-to-clear strobes for the pending register.
    always_comb begin
        pend_clr = '0;
        if (wr && !code_sel && code_idx == IDX_W'(ADDR_PEND))
            pend_clr = wdata;
    end

    // Read data mux.
    always_comb begin
        rdata = '0;
        if (code_sel) begin
            rdata = {{(N_PINS-CODE_W){1'b0}}, code_q[code_idx]};
        end else begin
            case (code_idx)
                IDX_W'(ADDR_DATA): rdata = pin_lvl;
                IDX_W'(ADDR_MASK): rdata = mask_q;
                IDX_W'(ADDR_POL):  rdata = pol_q;
                IDX_W'(ADDR_PEND): rdata = pend;
                default:           rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pinport_edge.sv
`timescale 1ns/1ps
// Module: one pin's input path. It synchronises the pin with two flops,
// keeps a third flop for edge detection, and latches qualified edges into a
// pending bit. Assumes pins idle high, so all flops reset to 1.
module pinport_edge
    import pinport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic falling,
    input  logic enable,
    input  logic clr,
    output logic level,
    output logic pend
);
    logic      sync1, sync2, last;
    logic      hit;
    edge_sel_e sel;

    // Synchroniser and history flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
            last  <= 1'b1;
        end else begin
            sync1 <= pin;
            sync2 <= sync1;
            last  <= sync2;
        end
    end

    // Edge qualification by polarity and mask.
    always_comb begin
        sel = falling ? EDGE_FALL : EDGE_RISE;
        case (sel)
            EDGE_FALL: hit = enable & ~sync2 & last;
            default:   hit = enable & sync2 & ~last;
        endcase
    end

    // Pending bit: a new edge beats a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else
            pend <= (pend & ~clr) | hit;
    end

    assign level = sync2;
endmodule

// File: rtl/pinport_pad.sv
`timescale 1ns/1ps
// Module: pad control mapping. It turns the data register into pull-up and
// sink enables, flattens the codes and marks the high-current pins.
// Assumes HI_PINS <= N_PINS.
module pinport_pad #(
    parameter int unsigned N_PINS  = 8,
    parameter int unsigned CODE_W  = 4,
    parameter int unsigned HI_PINS = 2
) (
    input  logic [N_PINS-1:0]             data_q,
    input  logic [N_PINS-1:0][CODE_W-1:0] code_q,
    output logic [N_PINS-1:0]             pu_en,
    output logic [N_PINS-1:0]             sink_en,
    output logic [N_PINS*CODE_W-1:0]      sink_code,
    output logic [N_PINS-1:0]             hi_class
);
    for (genvar i = 0; i < N_PINS; i++) begin : g_pad
        // A 1 releases the sink and pulls the pin up; a 0 sinks current.
        assign pu_en[i]   = data_q[i];
        assign sink_en[i] = ~data_q[i];
        assign sink_code[i*CODE_W +: CODE_W] = code_q[i];
        if (i < HI_PINS) begin : g_hi
            assign hi_class[i] = 1'b1;
        end else begin : g_lo
            assign hi_class[i] = 1'b0;
        end
    end
endmodule

// File: rtl/pinport_ctrl.sv
`timescale 1ns/1ps
// Module: top of the open-drain pin port. It ties the register file, the
// per-pin edge detectors and the pad mapping together and ORs the masked
// pending bits into one interrupt. Assumes a synchronous active-low reset.
module pinport_ctrl #(
    parameter int unsigned N_PINS  = 8,
    parameter int unsigned CODE_W  = 4,
    parameter int unsigned HI_PINS = 2,
    localparam int unsigned ADDR_W = $clog2(N_PINS) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [N_PINS-1:0]        bus_wdata,
    output logic [N_PINS-1:0]        bus_rdata,
    input  logic [N_PINS-1:0]        pin_in,
    output logic [N_PINS-1:0]        pu_en,
    output logic [N_PINS-1:0]        sink_en,
    output logic [N_PINS*CODE_W-1:0] sink_code,
    output logic [N_PINS-1:0]        hi_class,
    output logic                     irq
);
    logic [N_PINS-1:0]             data_q, mask_q, pol_q, pend_clr, pend_q, pin_lvl;
    logic [N_PINS-1:0][CODE_W-1:0] code_q;

    pinport_regs #(.N_PINS(N_PINS), .CODE_W(CODE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .pin_lvl(pin_lvl), .pend(pend_q),
        .rdata(bus_rdata), .data_q(data_q), .mask_q(mask_q),
        .pol_q(pol_q), .pend_clr(pend_clr), .code_q(code_q)
    );

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        pinport_edge u_edge (
            .clk(clk), .rst_n(rst_n), .pin(pin_in[i]),
            .falling(pol_q[i]), .enable(mask_q[i]), .clr(pend_clr[i]),
            .level(pin_lvl[i]), .pend(pend_q[i])
        );
    end

    pinport_pad #(.N_PINS(N_PINS), .CODE_W(CODE_W), .HI_PINS(HI_PINS)) u_pad (
        .data_q(data_q), .code_q(code_q), .pu_en(pu_en),
        .sink_en(sink_en), .sink_code(sink_code), .hi_class(hi_class)
    );

    // Single port interrupt from pending pins that are still enabled.
    assign irq = |(pend_q & mask_q);
endmodule

// File: rtl/pinport_chk.sv
`timescale 1ns/1ps
// Module: assertion checker bound to pinport_ctrl. It observes the bus,
// the pad outputs and the mask and pending state.
module pinport_chk #(
    parameter int unsigned N_PINS = 8,
    parameter int unsigned CODE_W = 4,
    localparam int unsigned IDX_W  = $clog2(N_PINS),
    localparam int unsigned ADDR_W = IDX_W + 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [N_PINS-1:0]        bus_wdata,
    input logic [N_PINS-1:0]        pu_en,
    input logic [N_PINS-1:0]        sink_en,
    input logic [N_PINS*CODE_W-1:0] sink_code,
    input logic [N_PINS-1:0]        mask_q,
    input logic [N_PINS-1:0]        pend_q
);
    // R1
    data_write_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0) |=> (pu_en == $past(bus_wdata)));

    // R2
    sink_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sink_en == ~pu_en));

    // R4
    code_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[ADDR_W-1])
        |=> (sink_code[$past(bus_addr[IDX_W-1:0])*CODE_W +: CODE_W]
             == $past(bus_wdata[CODE_W-1:0])));

    // R6
    masked_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ((pend_q & ~$past(pend_q) & ~$past(mask_q)) == '0));
endmodule

bind pinport_ctrl pinport_chk #(.N_PINS(N_PINS), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/pinport_ctrl_tb.sv
`timescale 1ns/1ps
// Bench for pinport_ctrl: directed corner cases followed by seeded random
// pin activity, checked against a bench-side model.
module pinport_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = 8'hFF;
    logic [7:0]  pu_en, sink_en, hi_class;
    logic [31:0] sink_code;
    logic        irq;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;

    logic [7:0] m_mask = '0, m_pol = '0, m_pend = '0, m_pins = 8'hFF;
    logic [3:0] m_code [8];

    always #2 clk = ~clk;

    pinport_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pu_en(pu_en), .sink_en(sink_en), .sink_code(sink_code),
        .hi_class(hi_class), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_pins(input logic [7:0] p);
        @(negedge clk);
        pin_in = p;
    endtask

    function automatic logic [7:0] edges(input logic [7:0] old_p, input logic [7:0] new_p,
                                         input logic [7:0] pol, input logic [7:0] msk);
        return msk & ((~pol & ~old_p & new_p) | (pol & old_p & ~new_p));
    endfunction

    initial begin
        #(4 * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 pu_en", pu_en, 8'hFF);
        chk("R10 sink_en", sink_en, 8'h00);
        chk("R10 sink_code", sink_code, 32'h0);
        chk("R10 irq", irq, 0);
        rd(4'h1, r); chk("R10 mask", r, 8'h00);
        rd(4'h2, r); chk("R10 pol", r, 8'h00);
        rd(4'h3, r); chk("R10 pend", r, 8'h00);
        rd(4'h0, r); chk("R10 data read", r, 8'hFF);
        // R5 class flags
        chk("R5 hi_class", hi_class, 8'h03);

        // R1 / R2 data drives pad enables
        wr(4'h0, 8'hA5);
        chk("R1 pu_en", pu_en, 8'hA5);
        chk("R2 sink_en", sink_en, 8'h5A);
        wr(4'h0, 8'hFF);
        chk("R1 all released", pu_en, 8'hFF);

        // R4 sink codes
        for (int i = 0; i < 8; i++) begin
            m_code[i] = 4'(i * 5 + 3);
            wr(4'(8 + i), {4'hF, m_code[i]});
        end
        for (int i = 0; i < 8; i++) begin
            chk("R4 code out", sink_code[i*4 +: 4], m_code[i]);
            rd(4'(8 + i), r); chk("R4 code read", r, {4'h0, m_code[i]});
        end

        // R3 read-back latency
        set_pins(8'h3C);
        @(negedge clk); rd(4'h0, r); chk("R3 early", r, 8'hFF);
        @(negedge clk); rd(4'h0, r); chk("R3 on time", r, 8'h3C);
        set_pins(8'hFF);
        repeat (3) @(negedge clk);

        // R7 / R9: pin0 rising selected, falling ignored
        wr(4'h1, 8'h01);
        set_pins(8'hFE);
        repeat (3) @(negedge clk);
        chk("R7 opposite edge ignored", irq, 0);
        rd(4'h3, r); chk("R7 pend after fall", r, 8'h00);
        set_pins(8'hFF);
        repeat (2) @(negedge clk);
        chk("R9 irq one edge early", irq, 0);
        @(negedge clk);
        chk("R9 irq on time", irq, 1);
        rd(4'h3, r); chk("R8 pend read", r, 8'h01);

        // R8 clear semantics
        wr(4'h3, 8'hFE);
        rd(4'h3, r); chk("R8 write 0 keeps", r, 8'h01);
        wr(4'h3, 8'h01);
        rd(4'h3, r); chk("R8 write 1 clears", r, 8'h00);
        chk("R9 irq drops", irq, 0);

        // R6 unmasked pin edge
        set_pins(8'hFB);
        set_pins(8'hFF);
        repeat (3) @(negedge clk);
        rd(4'h3, r); chk("R6 unmasked pend", r, 8'h00);
        chk("R6 unmasked irq", irq, 0);

        // R7 falling polarity on pin 5
        wr(4'h1, 8'h20); wr(4'h2, 8'h20);
        set_pins(8'hDF);
        repeat (3) @(negedge clk);
        rd(4'h3, r); chk("R7 falling latched", r, 8'h20);
        wr(4'h3, 8'hFF);
        set_pins(8'hFF);
        repeat (3) @(negedge clk);

        // Random phase
        void'($urandom(32'd7321));
        m_pins = 8'hFF; m_pend = 8'h00; m_mask = 8'h20; m_pol = 8'h20;
        for (int it = 0; it < 200; it++) begin
            logic [7:0] np;
            if ($urandom_range(0, 3) == 0) begin
                m_mask = 8'($urandom); wr(4'h1, m_mask);
            end
            if ($urandom_range(0, 3) == 0) begin
                m_pol = 8'($urandom); wr(4'h2, m_pol);
            end
            np = 8'($urandom);
            set_pins(np);
            m_pend = m_pend | edges(m_pins, np, m_pol, m_mask);
            m_pins = np;
            repeat (3) @(negedge clk);
            rd(4'h3, r); chk("R6/R7 random pend", r, m_pend);
            chk("R9 random irq", irq, |(m_pend & m_mask));
            rd(4'h0, r); chk("R3 random level", r, m_pins);
            if ($urandom_range(0, 2) == 0) begin
                logic [7:0] c;
                c = 8'($urandom);
                wr(4'h3, c);
                m_pend = m_pend & ~c;
                rd(4'h3, r); chk("R8 random clear", r, m_pend);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule